// File: doc/BRIEF.md
# Indexed Configuration Space Controller

This block holds the configuration registers of a multi-function peripheral chip. A host reaches every register through one pair of byte ports. A write to the lower port of the pair loads a register index. A read or write of the upper port then reaches the register that the index names.

A small set of global registers gives a fixed chip identifier, a revision byte and a logical-device selector. Each logical device has its own bank of registers behind the selector: an activate bit and a 16-bit I/O base address. The general-purpose pin device also has an indirect window. A pin-select register picks one pin, and a second register reads or writes that pin's three configuration bits.

The block drives the settings straight out as flat vectors to the device functions, which sit outside it. A strap input picks which of two fixed addresses the port pair decodes at.

Top module: `cfg_space_ctrl`

## Requirements
- R1: With `strap_alt` low the pair decodes at 0x002E (index) and 0x002F (data); with it high at 0x004E and 0x004F. A write to the index port loads the index, and a read of the index port returns it. Accesses to any other address change nothing and read 0x00, and `bus_rdata` is 0x00 whenever no read hits the pair.
- R2: Index 0x20 reads the chip identifier 0xE9 and index 0x27 reads the revision byte (default 0x01). Writes to either are ignored.
- R3: Index 0x07 is the logical device selector, a full 8-bit read/write register. Devices 0x00 to 0x0E own register banks. While a number of 0x0F or more is selected, the banked indices read 0x00 and ignore writes.
- R4: Index 0x30 is the selected device's activate register. Bit 0 drives `dev_active[n]`, reads return that bit in bit 0 with bits 7:1 zero, and upper write bits are dropped.
- R5: Indices 0x60 and 0x61 hold the high and low bytes of the selected device's base address, driven on `dev_base[16n+15:16n]`.
- R6: While device 0x07 is selected, index 0xF0 is the pin selector. Bits 6:4 hold the port and bits 2:0 the bit, so the pin number is port*8+bit. Reads return the written value with bits 7 and 3 zero. While another device is selected, 0xF0 reads 0x00 and ignores writes.
- R7: While device 0x07 is selected, index 0xF1 reads and writes the selected pin's configuration. Bit 0 is output enable, bit 1 is push-pull (clear means open-drain) and bit 2 is pull-up, driven on `pin_cfg[3p+2:3p]` in the same order. Bits 7:3 read zero. If the selected port is 4 or above, 0xF1 reads 0x00 and ignores writes.
- R8: Reset clears the index, the device selector, the pin selector, every activate bit, every base address and every pin configuration to zero.
- R9: All other indices read 0x00, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_alt | input | 1 | Picks the alternate port pair address |
| bus_addr | input | 16 | Host I/O address |
| bus_wr | input | 1 | Host write strobe, one cycle per write |
| bus_rd | input | 1 | Host read strobe |
| bus_wdata | input | 8 | Host write data |
| bus_rdata | output | 8 | Read data, combinational from address and state |
| dev_active | output | 15 | Activate bit of each logical device |
| dev_base | output | 240 | Base address of each device, 16 bits per device |
| pin_cfg | output | 96 | Configuration of each pin, 3 bits per pin |

## Verification
A wrong index, device selector or pin selector stays hidden until the next data-port access. That access then lands on the wrong bank or pin. A read shows the error in the same cycle, while a write shows it on the flat outputs one clock after the write edge. Every stored field can be read back, so the bench compares each read with a model built from the requirements. After directed and random write bursts it also compares every output vector, which catches writes that reached the wrong device or pin even when no later read touches them. The directed cases cover strap switching, the out-of-range device selector, the out-of-range pin port and writes to read-only or unused indices.

// File: rtl/cfg_space_pkg.sv
package cfg_space_pkg;
   localparam logic [7:0] IDX_LDN     = 8'h07;
   localparam logic [7:0] IDX_CHIPID  = 8'h20;
   localparam logic [7:0] IDX_REV     = 8'h27;
   localparam logic [7:0] IDX_ACT     = 8'h30;
   localparam logic [7:0] IDX_BASE_HI = 8'h60;
   localparam logic [7:0] IDX_BASE_LO = 8'h61;
   localparam logic [7:0] IDX_PINSEL  = 8'hF0;
   localparam logic [7:0] IDX_PINCFG  = 8'hF1;

   localparam int PIN_CFG_W = 3;

   // bit 2 pull-up, bit 1 push-pull, bit 0 output enable
   typedef struct packed {
      logic pull_up;
      logic push_pull;
      logic out_en;
   } pin_cfg_t;
endpackage

// File: rtl/cfg_port_decode.sv
module cfg_port_decode #(
   parameter int          ADDR_W   = 16,
   parameter logic [15:0] BASE_PRI = 16'h002E,
   parameter logic [15:0] BASE_ALT = 16'h004E
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              strap_alt,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [7:0]        bus_wdata,
   output logic [7:0]        idx_q,
   output logic              idx_rd,
   output logic              data_wr,
   output logic              data_rd
);
   localparam logic [ADDR_W-1:0] PRI = BASE_PRI[ADDR_W-1:0];
   localparam logic [ADDR_W-1:0] ALT = BASE_ALT[ADDR_W-1:0];

   if (PRI[0] != 1'b0 || ALT[0] != 1'b0) begin : g_bad_base
      $error("port pair bases must be even");
   end
   if (ADDR_W < 2 || ADDR_W > 16) begin : g_bad_aw
      $error("ADDR_W out of range");
   end

   logic [ADDR_W-1:0] base;
   logic              hit;

   assign base    = strap_alt ? ALT : PRI;
   assign hit     = (bus_addr[ADDR_W-1:1] == base[ADDR_W-1:1]);
   assign idx_rd  = hit && bus_rd && !bus_addr[0];
   assign data_rd = hit && bus_rd &&  bus_addr[0];
   assign data_wr = hit && bus_wr &&  bus_addr[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         idx_q <= 8'h00;
      else if (hit && bus_wr && !bus_addr[0])
         idx_q <= bus_wdata;
   end
endmodule

// File: rtl/cfg_dev_bank.sv
module cfg_dev_bank
   import cfg_space_pkg::*;
#(
   parameter int NUM_DEV = 15
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [7:0]            ldn,
   input  logic [7:0]            idx,
   input  logic                  data_wr,
   input  logic [7:0]            wdata,
   output logic [NUM_DEV-1:0]    dev_active,
   output logic [NUM_DEV*16-1:0] dev_base,
   output logic [7:0]            rd_val,
   output logic                  rd_hit
);
   if (NUM_DEV < 1 || NUM_DEV > 256) begin : g_bad_nd
      $error("NUM_DEV out of range");
   end

   logic        act_q  [NUM_DEV];
   logic [15:0] base_q [NUM_DEV];
   logic        ldn_ok;

   assign ldn_ok = (32'(ldn) < NUM_DEV);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int d = 0; d < NUM_DEV; d++) begin
            act_q[d]  <= 1'b0;
            base_q[d] <= 16'h0000;
         end
      end else if (data_wr && ldn_ok) begin
         for (int d = 0; d < NUM_DEV; d++) begin
            if (ldn == 8'(d)) begin
               if (idx == IDX_ACT)     act_q[d]        <= wdata[0];
               if (idx == IDX_BASE_HI) base_q[d][15:8] <= wdata;
               if (idx == IDX_BASE_LO) base_q[d][7:0]  <= wdata;
            end
         end
      end
   end

   for (genvar d = 0; d < NUM_DEV; d++) begin : g_out
      assign dev_active[d]        = act_q[d];
      assign dev_base[d*16 +: 16] = base_q[d];
   end

   always_comb begin
      rd_val = 8'h00;
      rd_hit = 1'b0;
      for (int d = 0; d < NUM_DEV; d++) begin
         if (ldn == 8'(d)) begin
            case (idx)
               IDX_ACT:     begin rd_val = {7'b0, act_q[d]}; rd_hit = 1'b1; end
               IDX_BASE_HI: begin rd_val = base_q[d][15:8];  rd_hit = 1'b1; end
               IDX_BASE_LO: begin rd_val = base_q[d][7:0];   rd_hit = 1'b1; end
               default: ;
            endcase
         end
      end
   end
endmodule

// File: rtl/cfg_gpio_pins.sv
module cfg_gpio_pins
   import cfg_space_pkg::*;
#(
   parameter int NUM_PORTS     = 4,
   parameter int PINS_PER_PORT = 8
) (
   input  logic                                      clk,
   input  logic                                      rst_n,
   input  logic                                      gpio_sel,
   input  logic [7:0]                                idx,
   input  logic                                      data_wr,
   input  logic [7:0]                                wdata,
   output logic [NUM_PORTS*PINS_PER_PORT*PIN_CFG_W-1:0] pin_cfg,
   output logic [7:0]                                rd_val,
   output logic                                      rd_hit
);
   localparam int NUM_PINS = NUM_PORTS * PINS_PER_PORT;

   if (NUM_PORTS < 1 || NUM_PORTS > 8) begin : g_bad_np
      $error("NUM_PORTS must be 1..8");
   end
   if (PINS_PER_PORT < 1 || PINS_PER_PORT > 8) begin : g_bad_pp
      $error("PINS_PER_PORT must be 1..8");
   end

   logic [2:0] sel_port;
   logic [2:0] sel_bit;
   logic       sel_ok;
   pin_cfg_t   cfg_q [NUM_PINS];
   pin_cfg_t   cur_cfg;

   assign sel_ok = (32'(sel_port) < NUM_PORTS) && (32'(sel_bit) < PINS_PER_PORT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_port <= 3'd0;
         sel_bit  <= 3'd0;
      end else if (data_wr && gpio_sel && idx == IDX_PINSEL) begin
         sel_port <= wdata[6:4];
         sel_bit  <= wdata[2:0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int p = 0; p < NUM_PINS; p++) cfg_q[p] <= '0;
      end else if (data_wr && gpio_sel && sel_ok && idx == IDX_PINCFG) begin
         for (int p = 0; p < NUM_PINS; p++) begin
            if (sel_port == 3'(p / PINS_PER_PORT) && sel_bit == 3'(p % PINS_PER_PORT))
               cfg_q[p] <= wdata[PIN_CFG_W-1:0];
         end
      end
   end

   for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
      assign pin_cfg[p*PIN_CFG_W +: PIN_CFG_W] = cfg_q[p];
   end

   always_comb begin
      cur_cfg = '0;
      for (int p = 0; p < NUM_PINS; p++) begin
         if (sel_port == 3'(p / PINS_PER_PORT) && sel_bit == 3'(p % PINS_PER_PORT))
            cur_cfg = cfg_q[p];
      end
   end

   always_comb begin
      rd_val = 8'h00;
      rd_hit = 1'b0;
      if (gpio_sel) begin
         if (idx == IDX_PINSEL) begin
            rd_val = {1'b0, sel_port, 1'b0, sel_bit};
            rd_hit = 1'b1;
         end else if (idx == IDX_PINCFG) begin
            rd_val = sel_ok ? {5'b0, cur_cfg} : 8'h00;
            rd_hit = 1'b1;
         end
      end
   end
endmodule

// File: rtl/cfg_space_ctrl.sv
module cfg_space_ctrl
   import cfg_space_pkg::*;
#(
   parameter int          ADDR_W        = 16,
   parameter logic [15:0] BASE_PRI      = 16'h002E,
   parameter logic [15:0] BASE_ALT      = 16'h004E,
   parameter logic [7:0]  CHIP_ID       = 8'hE9,
   parameter logic [7:0]  CHIP_REV      = 8'h01,
   parameter int          NUM_DEV       = 15,
   parameter int          GPIO_DEV      = 7,
   parameter int          NUM_PORTS     = 4,
   parameter int          PINS_PER_PORT = 8
) (
   input  logic                                          clk,
   input  logic                                          rst_n,
   input  logic                                          strap_alt,
   input  logic [ADDR_W-1:0]                             bus_addr,
   input  logic                                          bus_wr,
   input  logic                                          bus_rd,
   input  logic [7:0]                                    bus_wdata,
   output logic [7:0]                                    bus_rdata,
   output logic [NUM_DEV-1:0]                            dev_active,
   output logic [NUM_DEV*16-1:0]                         dev_base,
   output logic [NUM_PORTS*PINS_PER_PORT*PIN_CFG_W-1:0]  pin_cfg
);
   if (GPIO_DEV < 0 || GPIO_DEV >= NUM_DEV) begin : g_bad_gpio
      $error("GPIO_DEV must name an existing device");
   end

   logic [7:0] idx_q;
   logic [7:0] ldn_q;
   logic       idx_rd, data_wr, data_rd;
   logic       gpio_sel;
   logic [7:0] bank_val, pin_val;
   logic       bank_hit, pin_hit;
   logic [7:0] data_val;

   cfg_port_decode #(
      .ADDR_W(ADDR_W), .BASE_PRI(BASE_PRI), .BASE_ALT(BASE_ALT)
   ) u_dec (
      .clk(clk), .rst_n(rst_n), .strap_alt(strap_alt),
      .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_wdata(bus_wdata), .idx_q(idx_q), .idx_rd(idx_rd),
      .data_wr(data_wr), .data_rd(data_rd)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         ldn_q <= 8'h00;
      else if (data_wr && idx_q == IDX_LDN)
         ldn_q <= bus_wdata;
   end

   assign gpio_sel = (ldn_q == 8'(GPIO_DEV));

   cfg_dev_bank #(.NUM_DEV(NUM_DEV)) u_bank (
      .clk(clk), .rst_n(rst_n), .ldn(ldn_q), .idx(idx_q),
      .data_wr(data_wr), .wdata(bus_wdata),
      .dev_active(dev_active), .dev_base(dev_base),
      .rd_val(bank_val), .rd_hit(bank_hit)
   );

   cfg_gpio_pins #(.NUM_PORTS(NUM_PORTS), .PINS_PER_PORT(PINS_PER_PORT)) u_pins (
      .clk(clk), .rst_n(rst_n), .gpio_sel(gpio_sel), .idx(idx_q),
      .data_wr(data_wr), .wdata(bus_wdata), .pin_cfg(pin_cfg),
      .rd_val(pin_val), .rd_hit(pin_hit)
   );

   always_comb begin
      case (idx_q)
         IDX_LDN:    data_val = ldn_q;
         IDX_CHIPID: data_val = CHIP_ID;
         IDX_REV:    data_val = CHIP_REV;
         default: begin
            if (bank_hit)     data_val = bank_val;
            else if (pin_hit) data_val = pin_val;
            else              data_val = 8'h00;
         end
      endcase
   end

   assign bus_rdata = idx_rd  ? idx_q :
                      data_rd ? data_val : 8'h00;
endmodule

// File: rtl/cfg_space_ctrl_chk.sv
module cfg_space_ctrl_chk #(
   parameter int          ADDR_W   = 16,
   parameter logic [15:0] BASE_PRI = 16'h002E,
   parameter logic [15:0] BASE_ALT = 16'h004E,
   parameter logic [7:0]  CHIP_ID  = 8'hE9,
   parameter int          DEV_W    = 15,
   parameter int          PIN_W    = 96
) (
   input logic              clk,
   input logic              rst_n,
   input logic              strap_alt,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              bus_wr,
   input logic              bus_rd,
   input logic [7:0]        bus_wdata,
   input logic [7:0]        bus_rdata,
   input logic [DEV_W-1:0]  dev_active,
   input logic [PIN_W-1:0]  pin_cfg,
   input logic [7:0]        idx
);
   logic [ADDR_W-1:0] chk_base;
   logic              chk_hit;
   assign chk_base = strap_alt ? BASE_ALT[ADDR_W-1:0] : BASE_PRI[ADDR_W-1:0];
   assign chk_hit  = (bus_addr == chk_base) || (bus_addr == (chk_base | 1));

   AST_IDX_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && chk_hit && !bus_addr[0]) |=> (idx == $past(bus_wdata))); // R1

   AST_QUIET_MISS: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_rd && chk_hit) |-> (bus_rdata == 8'h00)); // R1

   AST_CHIP_ID: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && chk_hit && bus_addr[0] && idx == 8'h20) |-> (bus_rdata == CHIP_ID)); // R2

   AST_ACT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_wr && chk_hit && bus_addr[0]) |=> $stable(dev_active)); // R4

   AST_PIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_wr && chk_hit && bus_addr[0]) |=> $stable(pin_cfg)); // R7

   AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && chk_hit && bus_addr[0] && idx == 8'h00) |-> (bus_rdata == 8'h00)); // R9
endmodule

bind cfg_space_ctrl cfg_space_ctrl_chk #(
   .ADDR_W(ADDR_W), .BASE_PRI(BASE_PRI), .BASE_ALT(BASE_ALT),
   .CHIP_ID(CHIP_ID), .DEV_W(NUM_DEV),
   .PIN_W(NUM_PORTS*PINS_PER_PORT*3)
) u_chk (
   .clk(clk), .rst_n(rst_n), .strap_alt(strap_alt), .bus_addr(bus_addr),
   .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
   .bus_rdata(bus_rdata), .dev_active(dev_active), .pin_cfg(pin_cfg),
   .idx(idx_q)
);

// File: tb/cfg_space_ctrl_tb.sv
module cfg_space_ctrl_tb;
   localparam int CLK_PERIOD = 10;
   localparam int ND = 15;
   localparam int NP = 32;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         strap_alt = 1'b0;
   logic [15:0]  bus_addr = 16'h0;
   logic         bus_wr = 1'b0;
   logic         bus_rd = 1'b0;
   logic [7:0]   bus_wdata = 8'h0;
   logic [7:0]   bus_rdata;
   logic [ND-1:0]    dev_active;
   logic [ND*16-1:0] dev_base;
   logic [NP*3-1:0]  pin_cfg;

   int total = 0;
   int bad = 0;

   // model state
   logic [7:0]  m_idx;
   logic [7:0]  m_ldn;
   logic [7:0]  m_psel;
   logic        m_act  [ND];
   logic [15:0] m_base [ND];
   logic [2:0]  m_pcfg [NP];

   always #(CLK_PERIOD/2) clk = ~clk;

   cfg_space_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .strap_alt(strap_alt), .bus_addr(bus_addr),
      .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .dev_active(dev_active), .dev_base(dev_base),
      .pin_cfg(pin_cfg)
   );

   function automatic logic [15:0] pbase();
      return strap_alt ? 16'h004E : 16'h002E;
   endfunction

   function automatic int pin_no();
      return int'(m_psel[6:4]) * 8 + int'(m_psel[2:0]);
   endfunction

   function automatic logic [7:0] exp_data(logic [7:0] i);
      case (i)
         8'h07: return m_ldn;
         8'h20: return 8'hE9;
         8'h27: return 8'h01;
         8'h30: return (m_ldn < ND) ? {7'b0, m_act[m_ldn]} : 8'h00;
         8'h60: return (m_ldn < ND) ? m_base[m_ldn][15:8] : 8'h00;
         8'h61: return (m_ldn < ND) ? m_base[m_ldn][7:0]  : 8'h00;
         8'hF0: return (m_ldn == 8'h07) ? m_psel : 8'h00;
         8'hF1: return (m_ldn == 8'h07 && m_psel[6:4] < 3'd4) ? {5'b0, m_pcfg[pin_no()]} : 8'h00;
         default: return 8'h00;
      endcase
   endfunction

   task automatic model_data_wr(logic [7:0] v);
      case (m_idx)
         8'h07: m_ldn = v;
         8'h30: if (m_ldn < ND) m_act[m_ldn] = v[0];
         8'h60: if (m_ldn < ND) m_base[m_ldn][15:8] = v;
         8'h61: if (m_ldn < ND) m_base[m_ldn][7:0] = v;
         8'hF0: if (m_ldn == 8'h07) m_psel = {1'b0, v[6:4], 1'b0, v[2:0]};
         8'hF1: if (m_ldn == 8'h07 && m_psel[6:4] < 3'd4) m_pcfg[pin_no()] = v[2:0];
         default: ;
      endcase
   endtask

   task automatic model_reset();
      m_idx = 0; m_ldn = 0; m_psel = 0;
      for (int d = 0; d < ND; d++) begin m_act[d] = 0; m_base[d] = 0; end
      for (int p = 0; p < NP; p++) m_pcfg[p] = 0;
   endtask

   task automatic check8(string req, logic [7:0] act, logic [7:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: got %02h expected %02h", req, act, exp);
      end
   endtask

   // raw bus write, model untouched
   task automatic bus_write(logic [15:0] a, logic [7:0] v);
      @(negedge clk);
      bus_addr = a; bus_wdata = v; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic bus_read(logic [15:0] a, output logic [7:0] v);
      @(negedge clk);
      bus_addr = a; bus_rd = 1'b1;
      #1 v = bus_rdata;
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   task automatic set_idx(logic [7:0] i);
      bus_write(pbase(), i);
      m_idx = i;
   endtask

   task automatic put(logic [7:0] i, logic [7:0] v);
      set_idx(i);
      bus_write(pbase() | 16'h1, v);
      model_data_wr(v);
   endtask

   task automatic get_chk(string req, logic [7:0] i);
      logic [7:0] v;
      set_idx(i);
      bus_read(pbase() | 16'h1, v);
      check8(req, v, exp_data(i));
   endtask

   task automatic check_outs(string req);
      int errs = 0;
      for (int d = 0; d < ND; d++) begin
         if (dev_active[d] !== m_act[d]) errs++;
         if (dev_base[d*16 +: 16] !== m_base[d]) errs++;
      end
      for (int p = 0; p < NP; p++)
         if (pin_cfg[p*3 +: 3] !== m_pcfg[p]) errs++;
      total++;
      if (errs != 0) begin
         bad++;
         $display("FAIL %s: %0d output fields differ, got errs=%0d expected 0", req, errs, errs);
      end
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [7:0] v;
      void'($urandom(32'd1357));
      model_reset();
      repeat (3) @(negedge clk);
      // R8 reset values
      check8("R8 rdata idle", bus_rdata, 8'h00);
      check_outs("R8 outputs after reset");
      rst_n = 1'b1;
      bus_read(16'h002E, v);
      check8("R8 index reset", v, 8'h00);
      get_chk("R8 selector reset", 8'h07);

      // R2 identity and read-only behaviour
      get_chk("R2 chip id", 8'h20);
      get_chk("R2 revision", 8'h27);
      put(8'h20, 8'h00);
      get_chk("R2 id write ignored", 8'h20);
      put(8'h27, 8'h55);
      get_chk("R2 rev write ignored", 8'h27);

      // R1 index readback, misses
      set_idx(8'h61);
      bus_read(16'h002E, v);
      check8("R1 index readback", v, 8'h61);
      bus_write(16'h004E, 8'h20);
      bus_read(16'h002E, v);
      check8("R1 other pair write ignored", v, 8'h61);
      bus_read(16'h004F, v);
      check8("R1 miss reads zero", v, 8'h00);

      // R4 R5 bank per device
      put(8'h07, 8'h03);
      put(8'h30, 8'hFF);
      put(8'h60, 8'h12);
      put(8'h61, 8'h34);
      put(8'h07, 8'h0E);
      put(8'h60, 8'hAB);
      put(8'h61, 8'hCD);
      get_chk("R4 inactive dev", 8'h30);
      put(8'h07, 8'h03);
      get_chk("R4 activate read", 8'h30);
      get_chk("R5 base hi", 8'h60);
      get_chk("R5 base lo", 8'h61);
      check_outs("R5 R4 outputs");

      // R3 out of range device
      put(8'h07, 8'h0F);
      get_chk("R3 selector readback", 8'h07);
      put(8'h30, 8'h01);
      put(8'h60, 8'h99);
      get_chk("R3 no bank read", 8'h60);
      check_outs("R3 no bank write");

      // R6 R7 pin window
      put(8'h07, 8'h02);
      put(8'hF0, 8'h25);
      get_chk("R6 pinsel hidden", 8'hF0);
      put(8'h07, 8'h07);
      get_chk("R6 pinsel untouched", 8'hF0);
      put(8'hF0, 8'hFF);
      get_chk("R6 pinsel mask", 8'hF0);
      put(8'hF1, 8'h07);
      get_chk("R7 bad port read", 8'hF1);
      check_outs("R7 bad port write");
      put(8'hF0, 8'h35);
      put(8'hF1, 8'hFE);
      get_chk("R7 pin cfg read", 8'hF1);
      put(8'hF0, 8'h00);
      put(8'hF1, 8'h05);
      get_chk("R7 pin0 read", 8'hF1);
      check_outs("R7 pin outputs");

      // R9 unused indices
      put(8'h31, 8'hFF);
      get_chk("R9 unused read", 8'h31);
      put(8'h00, 8'hFF);
      get_chk("R9 idx0 read", 8'h00);
      check_outs("R9 outputs unchanged");

      // R1 alternate strap
      strap_alt = 1'b1;
      set_idx(8'h20);
      bus_read(16'h004F, v);
      check8("R1 alt pair id", v, 8'hE9);
      bus_read(16'h002F, v);
      check8("R1 primary dead on alt", v, 8'h00);
      strap_alt = 1'b0;

      // random traffic
      for (int n = 0; n < 600; n++) begin
         logic [7:0] i;
         logic [7:0] w;
         case ($urandom % 10)
            0: i = 8'h07;
            1: i = 8'h30;
            2: i = 8'h60;
            3: i = 8'h61;
            4, 5: i = 8'hF0;
            6: i = 8'hF1;
            7: i = 8'h20;
            8: i = 8'h27;
            default: i = 8'($urandom);
         endcase
         w = 8'($urandom);
         if (i == 8'h07) w = ($urandom % 4 == 0) ? 8'h07 : 8'($urandom % 18);
         if ($urandom % 2 == 0) put(i, w);
         else get_chk("R3 R4 R5 R6 R7 R9 random read", i);
         if (n % 50 == 49) check_outs("R4 R5 R7 random outputs");
      end
      check_outs("R4 R5 R7 final outputs");

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule